// File: doc/BRIEF.md
# DMA Completion Response Readout Port

This block sits between the write side of a scatter-gather DMA engine and a memory-mapped register bus. Each time a descriptor finishes, the write path hands it one completion record. The record holds the number of bytes actually moved, an 8-bit error code and a flag that marks early termination. The block keeps these records in a small first-in first-out store until software collects them.

Software reads the oldest record through two read-only words. The word at byte offset 0x0 returns the byte count. The word at byte offset 0x4 returns the error code and the early-termination flag. A read of the second word that enables its top byte lane (byte 0x7) also removes the record from the store. Software can therefore look at the byte count first and retire the record with its last access.

When the store is full, the block raises a full flag to the descriptor dispatcher. The dispatcher then issues no more commands until software has freed a slot. Software must drain the port to keep transfers flowing.

Top module: `dma_resp_port`

## Requirements
- R1: A read with word select 0 (byte address bit 2 low) returns, one clock after the read strobe, the 32-bit byte count of the oldest stored record.
- R2: A read with word select 1 (byte address bit 2 high) returns, one clock after the read strobe, the error code in bits 7:0 and the early-termination flag in bit 8. Bits 31:9 read as zero.
- R3: A read with word select 1 and byte-enable bit 3 set removes the oldest record at that same clock edge. The next read then shows the following record.
- R4: A read with word select 0, or a read with word select 1 and byte-enable bit 3 clear, leaves the store unchanged.
- R5: A read while the store is empty returns zero and removes nothing. A record pushed afterwards is the first one read back.
- R6: The full output is high from the clock edge that stores the DEPTH-th record, and low while fewer records are held.
- R7: A push while the store is full and no removal happens in the same cycle is discarded. The stored records stay unchanged.
- R8: A push and a removal in the same cycle while full are both accepted. Full stays high and record order is kept.
- R9: After reset the store is empty, the full output is low and the read data is zero.
- R10: Records are read back in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| respValid | input | 1 | Completion record push strobe from the write path |
| respBytes | input | 32 | Actual bytes transferred |
| respError | input | 8 | Error code |
| respEarly | input | 1 | Early-termination flag |
| respFull | output | 1 | Store full; dispatcher must stop issuing commands |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | ADDR_W | Byte address of the read; bit 2 selects the word |
| rdByteEn | input | 4 | Byte-lane enables of the read |
| rdData | output | 32 | Registered read data |

## Verification
Read data is registered, so each read result is due exactly one clock after the strobe. A removal and a push both take effect at the edge that samples them. The full flag is therefore valid one edge after the push that fills the last slot, and it stays high across a same-cycle push and removal. The bench drives inputs on the falling edge and holds them across one rising edge. It samples the read data and the full flag on the next falling edge, which is the first point where the registered values have settled. It never samples in the same cycle as the edge that updates them.

// File: rtl/dma_resp_pkg.sv
package dma_resp_pkg;

  localparam int BYTES_W = 32;
  localparam int ERR_W   = 8;
  localparam int DATA_W  = 32;
  localparam int BE_W    = DATA_W / 8;

  typedef struct packed {
    logic [BYTES_W-1:0] bytes;
    logic [ERR_W-1:0]   err;
    logic               early;
  } resp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;   // store incoming record
    logic pop;    // retire head record
    logic load;   // capture read data
    logic selHi;  // select status word
    logic zero;   // return zero (empty store)
  } strobe_t;

endpackage

// File: rtl/dma_resp_ctrl.sv
module dma_resp_ctrl
  import dma_resp_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              respValid,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [BE_W-1:0]   rdByteEn,
  output strobe_t           strb,
  output logic              full
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic             empty;
  logic             hiWord;
  logic             popReq;

  assign empty  = (count == '0);
  assign full   = (count == CNT_MAX);
  assign hiWord = rdAddr[2];
  assign popReq = rdEn && hiWord && rdByteEn[BE_W-1];

  always_comb begin
    strb       = '0;
    strb.pop   = popReq && !empty;
    strb.push  = respValid && (!full || strb.pop);
    strb.load  = rdEn;
    strb.selHi = hiWord;
    strb.zero  = empty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      unique case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/dma_resp_data.sv
module dma_resp_data
  import dma_resp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  resp_t             inResp,
  output logic [DATA_W-1:0] rdData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam int PAD_W = DATA_W - ERR_W - 1;

  resp_t            store [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  resp_t            head;
  logic [DATA_W-1:0] loWord;
  logic [DATA_W-1:0] hiWord;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign head   = store[rdPtr];
  assign loWord = head.bytes;
  assign hiWord = {{PAD_W{1'b0}}, head.early, head.err};

  always_ff @(posedge clk) begin
    if (strb.push) store[wrPtr] <= inResp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      if (strb.load) begin
        if (strb.zero)       rdData <= '0;
        else if (strb.selHi) rdData <= hiWord;
        else                 rdData <= loWord;
      end
    end
  end

endmodule

// File: rtl/dma_resp_port.sv
module dma_resp_port
  import dma_resp_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              respValid,
  input  logic [31:0]       respBytes,
  input  logic [7:0]        respError,
  input  logic              respEarly,
  output logic              respFull,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [3:0]        rdByteEn,
  output logic [31:0]       rdData
);

  strobe_t strb;
  resp_t   inResp;

  assign inResp = '{bytes: respBytes, err: respError, early: respEarly};

  dma_resp_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .respValid (respValid),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .rdByteEn  (rdByteEn),
    .strb      (strb),
    .full      (respFull)
  );

  dma_resp_data #(.DEPTH(DEPTH)) i_data (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .inResp (inResp),
    .rdData (rdData)
  );

endmodule

// File: rtl/dma_resp_port_chk.sv
module dma_resp_port_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              respValid,
  input logic              respFull,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [3:0]        rdByteEn,
  input logic [31:0]       rdData
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  // independent occupancy model built from port activity
  logic [CNT_W-1:0] occ;
  logic popSeen;
  logic pushSeen;
  logic popAsk;

  assign popAsk   = rdEn && rdAddr[2] && rdByteEn[3];
  assign popSeen  = popAsk && (occ != '0);
  assign pushSeen = respValid && ((occ != CNT_W'(DEPTH)) || popSeen);

  always_ff @(posedge clk) begin
    if (!rstN) occ <= '0;
    else occ <= occ + CNT_W'(pushSeen) - CNT_W'(popSeen);
  end

  p_full_tracks_r6: assert property (@(posedge clk) disable iff (!rstN)
    respFull == (occ == CNT_W'(DEPTH)));

  p_empty_read_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && occ == '0) |=> (rdData == '0));

  p_status_pad_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr[2]) |=> (rdData[31:9] == '0));

  p_peek_keeps_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    (respFull && rdEn && !popAsk && !respValid) |=> respFull);

  p_swap_keeps_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    (respFull && respValid && popAsk) |=> respFull);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (respFull && respValid && !popAsk) |=> respFull);

endmodule

bind dma_resp_port dma_resp_port_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .respValid (respValid),
  .respFull  (respFull),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .rdByteEn  (rdByteEn),
  .rdData    (rdData)
);

// File: tb/test_dma_resp_port.sv
`timescale 1ns/1ps
module test_dma_resp_port;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        respValid;
  logic [31:0] respBytes;
  logic [7:0]  respError;
  logic        respEarly;
  logic        respFull;
  logic        rdEn;
  logic [2:0]  rdAddr;
  logic [3:0]  rdByteEn;
  logic [31:0] rdData;

  int nChecks = 0;
  int nErrors = 0;

  always #5 clk = ~clk;

  dma_resp_port #(.DEPTH(DEPTH), .ADDR_W(3)) i_dma_resp_port (
    .clk(clk), .rstN(rstN), .respValid(respValid), .respBytes(respBytes),
    .respError(respError), .respEarly(respEarly), .respFull(respFull),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdByteEn(rdByteEn), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    respValid = 0; rdEn = 0; rdAddr = 0; rdByteEn = 0;
    respBytes = 0; respError = 0; respEarly = 0;
  endtask

  // one-cycle push; inputs change on falling edge
  task automatic push(input logic [31:0] b, input logic [7:0] e, input logic t);
    @(negedge clk);
    idle();
    respValid = 1; respBytes = b; respError = e; respEarly = t;
    @(negedge clk);
    idle();
  endtask

  // one-cycle read; result sampled at the next falling edge
  task automatic rd(input logic [2:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    idle();
    rdEn = 1; rdAddr = a; rdByteEn = be;
    @(negedge clk);
    idle();
    d = rdData;
  endtask

  function automatic logic [31:0] stat(input logic [7:0] e, input logic t);
    return {23'd0, t, e};
  endfunction

  task automatic doReset();
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic test_reset();
    logic [31:0] d;
    doReset();
    check(respFull == 0, "R9 full low", {31'd0, respFull}, 0);
    check(rdData == 0, "R9 rdData zero", rdData, 0);
    rd(3'h4, 4'hF, d);
    check(d == 0, "R9 empty after reset", d, 0);
  endtask

  task automatic test_single();
    logic [31:0] d;
    doReset();
    push(32'h0000_1234, 8'h5A, 1'b1);
    rd(3'h0, 4'hF, d);
    check(d == 32'h1234, "R1 byte count", d, 32'h1234);
    rd(3'h4, 4'h7, d);
    check(d == stat(8'h5A, 1), "R2 status word", d, stat(8'h5A, 1));
    rd(3'h0, 4'hF, d);
    check(d == 32'h1234, "R4 low-lane read keeps head", d, 32'h1234);
    rd(3'h4, 4'h8, d);
    check(d == stat(8'h5A, 1), "R3 popping read data", d, stat(8'h5A, 1));
    rd(3'h0, 4'hF, d);
    check(d == 0, "R3 popped leaves store empty", d, 0);
  endtask

  task automatic test_empty();
    logic [31:0] d;
    doReset();
    rd(3'h4, 4'hF, d);
    check(d == 0, "R5 empty read zero", d, 0);
    rd(3'h4, 4'hF, d);
    push(32'hABCD, 8'h01, 0);
    rd(3'h0, 4'hF, d);
    check(d == 32'hABCD, "R5 no underflow", d, 32'hABCD);
  endtask

  task automatic test_order();
    logic [31:0] d;
    doReset();
    for (int i = 0; i < 3; i++) push(32'(100 + i), 8'(i), i[0]);
    for (int i = 0; i < 3; i++) begin
      rd(3'h0, 4'hF, d);
      check(d == 32'(100 + i), "R10 order bytes", d, 32'(100 + i));
      rd(3'h4, 4'hF, d);
      check(d == stat(8'(i), i[0]), "R10 order status", d, stat(8'(i), i[0]));
    end
  endtask

  task automatic test_fill_overflow();
    logic [31:0] d;
    doReset();
    for (int i = 0; i < DEPTH - 1; i++) push(32'(200 + i), 8'(i), 0);
    check(respFull == 0, "R6 not full at DEPTH-1", {31'd0, respFull}, 0);
    push(32'(200 + DEPTH - 1), 8'(DEPTH - 1), 0);
    check(respFull == 1, "R6 full at DEPTH", {31'd0, respFull}, 1);
    rd(3'h4, 4'h7, d);
    check(respFull == 1, "R4 peek keeps full", {31'd0, respFull}, 1);
    push(32'hDEAD, 8'hEE, 1);
    check(respFull == 1, "R7 still full", {31'd0, respFull}, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(3'h0, 4'hF, d);
      check(d == 32'(200 + i), "R7 contents intact", d, 32'(200 + i));
      rd(3'h4, 4'hF, d);
      if (i == 0)
        check(respFull == 0, "R6 full drops after pop", {31'd0, respFull}, 0);
    end
    rd(3'h0, 4'hF, d);
    check(d == 0, "R7 dropped record absent", d, 0);
  endtask

  task automatic test_full_swap();
    logic [31:0] d;
    doReset();
    for (int i = 0; i < DEPTH; i++) push(32'(300 + i), 8'(i), 0);
    @(negedge clk);
    idle();
    respValid = 1; respBytes = 32'h777; respError = 8'h77; respEarly = 1;
    rdEn = 1; rdAddr = 3'h4; rdByteEn = 4'hF;
    @(negedge clk);
    idle();
    check(rdData == stat(8'd0, 0), "R8 swap returns old head", rdData, stat(8'd0, 0));
    check(respFull == 1, "R8 full stays", {31'd0, respFull}, 1);
    for (int i = 1; i < DEPTH; i++) begin
      rd(3'h4, 4'hF, d);
      check(d == stat(8'(i), 0), "R8 order kept", d, stat(8'(i), 0));
    end
    rd(3'h0, 4'hF, d);
    check(d == 32'h777, "R8 pushed record stored", d, 32'h777);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    test_reset();
    test_single();
    test_empty();
    test_order();
    test_fill_overflow();
    test_full_swap();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule